// File: doc/BRIEF.md
# Instruction Fetch and Decode Front End with Early Branch Resolution

This block is the front of a small 32-bit pipeline. A word-indexed program counter addresses an instruction memory. The memory returns one 32-bit word in the same cycle. Each accepted word is captured in an instruction register, and the decode logic works on that register.

Decode splits the word into its fields, reads two operands from a 32-entry register file and sign-extends the 16-bit immediate. It presents the result to an execute stage over a valid/ready handshake. Conditional branches and jumps are resolved in decode, and the fetch address is redirected there. The word that was fetched behind a taken branch or jump is replaced by an all-zero no-op before it goes downstream.

An all-ones word marks the end of the program. When that word reaches decode, the block stops issuing and freezes until the next reset. Register writes come back from later stages through a write port. A write to a register is visible to a read of that register in the same cycle.

Top module: `fetch_decode`

## Requirements
- R1: During reset `imem_addr` is 0 and `dx_valid` is low. The first record carries `dx_pc` 0. Each following record in straight-line code carries the previous `dx_pc` plus 1.
- R2: `dx_op` equals instruction bits 31:26, `dx_shamt` equals bits 10:6 and `dx_funct` equals bits 5:0.
- R3: `dx_dest` is selected from the opcode as follows:
  - opcode 000000: bits 15:11;
  - opcode 001xxx or 100011: bits 20:16;
  - any other opcode: 0.
- R4: `dx_imm` is bits 15:0 of the instruction, sign-extended to 32 bits.
- R5: `dx_a` is the register selected by bits 25:21 and `dx_b` is the register selected by bits 20:16. Register 0 always reads 0 and ignores writes. A write in progress to the selected register is returned in the same cycle.
- R6: A taken redirect sets the next real record's address as follows:
  - opcode 000100 (branch if equal) or 000101 (branch if not equal), when the condition holds: the branch's address plus 1 plus the signed offset in bits 15:0, in words;
  - opcode 000010 (jump), always: the low address bits of bits 25:0.
- R7: The record that follows a taken redirect is a no-op. Its `dx_op`, `dx_funct`, `dx_shamt`, `dx_dest` and `dx_imm` are all zero.
- R8: When the word 0xFFFFFFFF reaches decode, three things happen and persist until reset:
  - `halt` rises;
  - `dx_valid` drops;
  - `imem_addr` freezes.
- R9: While `dx_valid` is high and `dx_ready` is low, the presented record and `imem_addr` do not change.
- R10: A conditional branch whose condition fails is not squashed. The next record is the instruction at the branch's address plus 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | AW | Word address of the instruction to fetch |
| imem_word | input | 32 | Instruction word at `imem_addr`, same cycle |
| wb_en | input | 1 | Register write enable |
| wb_sel | input | 5 | Register write index |
| wb_data | input | 32 | Register write data |
| dx_valid | output | 1 | Decoded record is valid |
| dx_ready | input | 1 | Execute stage accepts the record |
| dx_pc | output | AW | Word address of the decoded instruction |
| dx_op | output | 6 | Opcode field |
| dx_funct | output | 6 | Function field |
| dx_shamt | output | 5 | Shift amount field |
| dx_dest | output | 5 | Destination register index |
| dx_a | output | 32 | First operand |
| dx_b | output | 32 | Second operand |
| dx_imm | output | 32 | Sign-extended immediate |
| halt | output | 1 | End-of-program marker reached |

## Verification
The program walks the field positions through an arithmetic sweep of register-format, immediate-format, load and store words, with varied register indices and immediates of both signs. This separates mistakes in field slicing, destination choice and sign extension.

A chain of control transfers covers three situations:
- branches taken forward and with a negative offset, and a taken branch whose target equals the fall-through address, which shows the squash is unconditional;
- branches not taken in both polarities;
- two jumps.

The execute-side ready follows a periodic pattern, so that stalls fall on ordinary words, on branches and on squashed slots. Register writes arriving during a stall expose the same-cycle bypass and the hard-wired zero register.

// File: rtl/fetch_decode.sv
module fetch_decode #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] imem_addr,
  input  logic [31:0]   imem_word,
  input  logic          wb_en,
  input  logic [4:0]    wb_sel,
  input  logic [31:0]   wb_data,
  output logic          dx_valid,
  input  logic          dx_ready,
  output logic [AW-1:0] dx_pc,
  output logic [5:0]    dx_op,
  output logic [5:0]    dx_funct,
  output logic [4:0]    dx_shamt,
  output logic [4:0]    dx_dest,
  output logic [31:0]   dx_a,
  output logic [31:0]   dx_b,
  output logic [31:0]   dx_imm,
  output logic          halt
);

  localparam logic [5:0] OP_J   = 6'b000010;
  localparam logic [5:0] OP_BEQ = 6'b000100;
  localparam logic [5:0] OP_BNE = 6'b000101;
  localparam logic [5:0] OP_LW  = 6'b100011;

  logic [AW-1:0] pc, ir_pc;
  logic [31:0]   ir;
  logic          ir_vld;
  logic [31:0]   rf [32];

  logic [4:0]    rs, rt;
  logic          same, take, fire, advance;
  logic [AW-1:0] target;

  assign rs        = ir[25:21];
  assign rt        = ir[20:16];
  assign dx_op     = ir[31:26];
  assign dx_shamt  = ir[10:6];
  assign dx_funct  = ir[5:0];
  assign dx_imm    = {{16{ir[15]}}, ir[15:0]};
  assign dx_pc     = ir_pc;
  assign imem_addr = pc;

  assign dx_dest = (dx_op == 6'd0) ? ir[15:11] :
                   (dx_op[5:3] == 3'b001 || dx_op == OP_LW) ? rt : 5'd0;

  assign dx_a = (rs == 5'd0) ? 32'd0 : (wb_en && wb_sel == rs) ? wb_data : rf[rs];
  assign dx_b = (rt == 5'd0) ? 32'd0 : (wb_en && wb_sel == rt) ? wb_data : rf[rt];

  assign halt     = ir_vld && (ir == 32'hFFFF_FFFF);
  assign dx_valid = ir_vld && !halt;
  assign fire     = dx_valid && dx_ready;
  assign advance  = !ir_vld || fire;

  assign same   = (dx_a == dx_b);
  assign take   = (dx_op == OP_J) || (dx_op == OP_BEQ && same) || (dx_op == OP_BNE && !same);
  assign target = (dx_op == OP_J) ? ir[AW-1:0] : ir_pc + AW'(1) + dx_imm[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= '0;
      ir_pc  <= '0;
      ir     <= '0;
      ir_vld <= 1'b0;
    end else if (advance) begin
      ir_vld <= 1'b1;
      ir_pc  <= pc;
      if (fire && take) begin
        ir <= 32'd0;
        pc <= target;
      end else begin
        ir <= imem_word;
        pc <= pc + AW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else if (wb_en && wb_sel != 5'd0) begin
      rf[wb_sel] <= wb_data;
    end
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !take |=> imem_addr == $past(imem_addr) + AW'(1)); // R1

  AST_REDIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    fire && take |=> imem_addr == $past(target)); // R6

  AST_SQUASH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && take |=> dx_valid && dx_op == 6'd0 && dx_funct == 6'd0 && dx_dest == 5'd0); // R7

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt && !dx_valid && $stable(imem_addr)); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dx_valid && !dx_ready |=> dx_valid && $stable(dx_pc) && $stable(dx_op) && $stable(imem_addr)); // R9

endmodule

// File: tb/test_fetch_decode.sv
module test_fetch_decode;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_word;
  logic          wb_en;
  logic [4:0]    wb_sel;
  logic [31:0]   wb_data;
  logic          dx_valid, dx_ready, halt;
  logic [AW-1:0] dx_pc;
  logic [5:0]    dx_op, dx_funct;
  logic [4:0]    dx_shamt, dx_dest;
  logic [31:0]   dx_a, dx_b, dx_imm;

  logic [31:0] imem [256];
  logic [31:0] sh [32];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;
  assign imem_word = imem[imem_addr];

  fetch_decode #(.AW(AW)) i_fetch_decode (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_word(imem_word),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data),
    .dx_valid(dx_valid), .dx_ready(dx_ready), .dx_pc(dx_pc), .dx_op(dx_op),
    .dx_funct(dx_funct), .dx_shamt(dx_shamt), .dx_dest(dx_dest),
    .dx_a(dx_a), .dx_b(dx_b), .dx_imm(dx_imm), .halt(halt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sa, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sa), 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] gen(int k);
    int op;
    case (k % 4)
      0: op = 0;
      1: op = 8 + (k % 8);
      2: op = 35;
      default: op = 43;
    endcase
    if (op == 0) return enc_r(k % 32, (k * 7) % 32, (k * 13) % 32, (k * 5) % 32, k * 3);
    return enc_i(op, k % 32, (k * 7) % 32, ((k * 1237) & 16'h7FFF) | ((k % 2) << 15));
  endfunction

  function automatic logic [4:0] exp_dest(logic [31:0] w);
    if (w[31:26] == 6'd0) return w[15:11];
    if (w[31:29] == 3'b001 || w[31:26] == 6'b100011) return w[20:16];
    return 5'd0;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=halt");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int mpc;
    bit squash, last_nt, last_tk, stallpend;
    logic [AW-1:0] s_pc;
    logic [5:0] s_op;

    for (int i = 0; i < 256; i++) imem[i] = enc_i(8, 0, 0, i);
    imem[0] = enc_r(1, 0, 3, 0, 32);
    for (int k = 1; k <= 40; k++) imem[k] = gen(k);
    imem[41]  = enc_i(4, 5, 5, 3);
    imem[45]  = enc_i(5, 1, 1, 5);
    imem[46]  = enc_i(4, 1, 2, -10);
    imem[47]  = {6'd2, 26'd100};
    imem[100] = enc_i(5, 2, 3, -51);
    imem[50]  = enc_i(4, 0, 0, 0);
    imem[51]  = {6'd2, 26'd52};
    for (int k = 52; k <= 59; k++) imem[k] = gen(k);
    imem[60]  = 32'hFFFF_FFFF;
    for (int i = 0; i < 32; i++) sh[i] = (i == 0) ? 32'd0 : (32'(i) * 32'h0100_0193) ^ 32'h5A5A_0000;

    rst_n = 1'b0; dx_ready = 1'b0; wb_en = 1'b0; wb_sel = '0; wb_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset dx_valid", 32'(dx_valid), 0);
    chk("R1 reset imem_addr", 32'(imem_addr), 0);
    chk("R8 reset halt", 32'(halt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first record valid", 32'(dx_valid), 1);
    chk("R1 first record pc", 32'(dx_pc), 0);
    chk("R1 fetch step", 32'(imem_addr), 1);

    for (int i = 0; i < 32; i++) begin
      wb_en = 1'b1; wb_sel = 5'(i); wb_data = (i == 0) ? 32'hFFFF_FFFF : sh[i];
      @(negedge clk);
    end
    wb_en = 1'b0;
    chk("R9 stall keeps pc", 32'(dx_pc), 0);
    chk("R9 stall keeps fetch addr", 32'(imem_addr), 1);
    chk("R9 stall keeps valid", 32'(dx_valid), 1);

    wb_en = 1'b1; wb_sel = 5'd1; wb_data = 32'hA5A5_1234;
    #1 chk("R5 same-cycle bypass", dx_a, 32'hA5A5_1234);
    @(negedge clk);
    wb_sel = 5'd0; wb_data = 32'hFFFF_FFFF;
    #1 chk("R5 register 0 reads zero", dx_b, 0);
    chk("R5 written value kept", dx_a, 32'hA5A5_1234);
    @(negedge clk);
    wb_en = 1'b0;
    sh[1] = 32'hA5A5_1234;

    mpc = 0; squash = 0; last_nt = 0; last_tk = 0; stallpend = 0;
    s_pc = '0; s_op = '0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      bit rdy;
      if (cyc != 0) @(negedge clk);
      if (halt) break;
      if (stallpend) begin
        chk("R9 stalled pc stable", 32'(dx_pc), 32'(s_pc));
        chk("R9 stalled op stable", 32'(dx_op), 32'(s_op));
      end
      rdy = (cyc % 5) != 2;
      dx_ready = rdy;
      stallpend = dx_valid && !rdy;
      s_pc = dx_pc; s_op = dx_op;
      if (dx_valid && rdy) begin
        if (squash) begin
          chk("R7 squash op", 32'(dx_op), 0);
          chk("R7 squash funct", 32'(dx_funct), 0);
          chk("R7 squash shamt", 32'(dx_shamt), 0);
          chk("R7 squash dest", 32'(dx_dest), 0);
          chk("R7 squash imm", dx_imm, 0);
          squash = 0;
        end else begin
          logic [31:0] w;
          logic [31:0] sx;
          bit tk;
          w = imem[mpc];
          sx = {{16{w[15]}}, w[15:0]};
          if (last_nt) chk("R10 fall-through pc", 32'(dx_pc), 32'(mpc));
          else if (last_tk) chk("R6 redirect pc", 32'(dx_pc), 32'(mpc));
          else chk("R1 sequential pc", 32'(dx_pc), 32'(mpc));
          chk("R2 op field", 32'(dx_op), 32'(w[31:26]));
          chk("R2 funct field", 32'(dx_funct), 32'(w[5:0]));
          chk("R2 shamt field", 32'(dx_shamt), 32'(w[10:6]));
          chk("R3 destination", 32'(dx_dest), 32'(exp_dest(w)));
          chk("R4 sign-extended imm", dx_imm, sx);
          chk("R5 operand a", dx_a, sh[w[25:21]]);
          chk("R5 operand b", dx_b, sh[w[20:16]]);
          tk = 0;
          last_nt = 0;
          if (w[31:26] == 6'd2) begin
            tk = 1; mpc = int'(w[AW-1:0]);
          end else if (w[31:26] == 6'd4 || w[31:26] == 6'd5) begin
            tk = (w[31:26] == 6'd4) == (sh[w[25:21]] == sh[w[20:16]]);
            if (tk) mpc = (mpc + 1 + int'($signed(sx))) & 255;
            else last_nt = 1;
          end
          if (!tk) mpc = mpc + 1;
          last_tk = tk;
          squash = tk;
        end
      end
    end

    chk("R8 halt raised", 32'(halt), 1);
    chk("R8 stream ends at marker", 32'(mpc), 60);
    chk("R8 fetch address frozen", 32'(imem_addr), 61);
    dx_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8 no issue after halt", 32'(dx_valid), 0);
      chk("R8 halt held", 32'(halt), 1);
      chk("R8 address held", 32'(imem_addr), 61);
    end

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears halt", 32'(halt), 0);
    chk("R1 reset clears address", 32'(imem_addr), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule